// File: doc/BRIEF.md
# Event Interrupt Controller with Set/Clear Mask

This block gathers single-cycle event pulses from the units around it and turns them into one interrupt request line. Five sources feed it: two timer underflows, a time-of-day alarm match, a serial byte completion and an edge on an external flag pin. Each pulse latches into a sticky flag bit. An enable mask decides which flags may raise the request.

The register side has one byte-wide data path and a select line that chooses between two registers. The status register is read-to-clear. It returns the pending flags together with a summary bit, and the flags are emptied at the end of the read cycle. The mask register is write-only. A write either sets or clears the bits chosen in its payload, and the payload's top bit picks which of the two it does. That way software can change single enables without reading the mask first.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the flags and the mask are zero, `irq` is low, and a status read returns 0x00.
- R2: A pulse on `evt_pulse[i]` sets flag i, and the flag stays set until a status read. The bit positions are: 0 timer A underflow, 1 timer B underflow, 2 time-of-day alarm, 3 serial data ready, 4 external flag.
- R3: A mask write with `wdata[7]`=1 sets every mask bit whose `wdata[4:0]` bit is 1. All other mask bits keep their value.
- R4: A mask write with `wdata[7]`=0 clears every mask bit whose `wdata[4:0]` bit is 1. All other mask bits keep their value.
- R5: Status bit 7 is 1 exactly when (flags AND mask) is nonzero, using the values registered at the current cycle. Bits 6:5 read 0, and bits 4:0 are the flags.
- R6: A status read (`reg_sel`=0, `rd_en`=1) returns the full byte in the same cycle and clears every flag at the following clock edge.
- R7: An event pulse that arrives in the same cycle as a status read is set in the flags after that read.
- R8: `irq` is registered. In each cycle it equals the status bit 7 value of the previous cycle.
- R9: Reading the mask address (`reg_sel`=1) returns 0x00, and a write to the status address leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 = status register, 1 = mask register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data; bit 7 selects set (1) or clear (0) for mask writes |
| rdata | output | 8 | Read data, valid in the cycle `rd_en` is high |
| evt_pulse | input | 5 | One-cycle event pulses, one per source |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that every event input is a one-cycle pulse sampled at the clock edge. They also assume that `reg_sel`, `rd_en` and `wr_en` are stable across each edge. They put no limit on reads and events arriving together, so the read-with-event corner is covered. The stimulus drives every input on the falling edge and holds it for exactly one cycle. It overlaps a status read with an event pulse on purpose, and it writes to the status address while no read is active, so the ignored-write case is not hidden by a clear.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int REG_W = 8;
  localparam int PAYLOAD_W = REG_W - 1;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;

  // Set/clear update of an enable vector; wd[REG_W-1] chooses the direction.
  function automatic logic [PAYLOAD_W-1:0] mask_apply(
    input logic [PAYLOAD_W-1:0] cur,
    input logic [REG_W-1:0]     wd
  );
    logic [PAYLOAD_W-1:0] pick;
    pick = wd[PAYLOAD_W-1:0];
    if (wd[REG_W-1]) mask_apply = cur | pick;
    else             mask_apply = cur & ~pick;
  endfunction

  // Any enabled flag pending.
  function automatic logic pending_any(
    input logic [PAYLOAD_W-1:0] flg,
    input logic [PAYLOAD_W-1:0] msk
  );
    pending_any = |(flg & msk);
  endfunction

endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all,
  input  logic [NUM_SRC-1:0] evt_pulse,
  output logic [NUM_SRC-1:0] flag_q
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    logic held;
    assign held = clr_all ? 1'b0 : flag_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= held | evt_pulse[i];
    end
  end

endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_mask,
  input  logic [REG_W-1:0]   wdata,
  output logic [NUM_SRC-1:0] mask_q
);

  localparam int PAD = PAYLOAD_W - NUM_SRC;

  logic [PAYLOAD_W-1:0] cur_wide;
  logic [PAYLOAD_W-1:0] nxt_wide;

  assign cur_wide = {{PAD{1'b0}}, mask_q};
  assign nxt_wide = mask_apply(cur_wide, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= nxt_wide[NUM_SRC-1:0];
  end

endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  output logic irq_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending;
  end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  input  logic [NUM_SRC-1:0] evt_pulse,
  output logic               irq
);

  localparam int PAD_STAT = REG_W - 1 - NUM_SRC;
  localparam int PAD_CMP  = PAYLOAD_W - NUM_SRC;

  logic [NUM_SRC-1:0] flag_vec;
  logic [NUM_SRC-1:0] mask_vec;
  logic               status_rd;
  logic               mask_wr;
  logic               any_pending;
  logic [REG_W-1:0]   status_byte;

  assign status_rd = rd_en && (reg_sel == SEL_STATUS);
  assign mask_wr   = wr_en && (reg_sel == SEL_MASK);

  assign any_pending = pending_any({{PAD_CMP{1'b0}}, flag_vec},
                                   {{PAD_CMP{1'b0}}, mask_vec});
  assign status_byte = {any_pending, {PAD_STAT{1'b0}}, flag_vec};
  assign rdata       = status_rd ? status_byte : '0;

  evt_flag_bank #(.NUM_SRC(NUM_SRC)) flags_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (status_rd),
    .evt_pulse(evt_pulse),
    .flag_q   (flag_vec)
  );

  evt_mask_reg #(.NUM_SRC(NUM_SRC)) mask_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_mask(mask_wr),
    .wdata  (wdata),
    .mask_q (mask_vec)
  );

  evt_irq_out irq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pending(any_pending),
    .irq_q  (irq)
  );

endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int NUM_SRC = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_sel,
  input logic               wr_en,
  input logic               rd_en,
  input logic               set_dir,
  input logic [NUM_SRC-1:0] wsel,
  input logic [NUM_SRC-1:0] evt_pulse,
  input logic               irq,
  input logic [NUM_SRC-1:0] flag_vec,
  input logic [NUM_SRC-1:0] mask_vec,
  input logic               any_pending
);

  a_r2_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((flag_vec & $past(evt_pulse)) == $past(evt_pulse)));

  a_r3_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel && set_dir) |=> ((mask_vec & $past(wsel)) == $past(wsel)));

  a_r4_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel && !set_dir) |=> ((mask_vec & $past(wsel)) == '0));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !reg_sel) |=> (flag_vec == $past(evt_pulse)));

  a_r8_irq_lags: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(any_pending)));

  a_r9_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel && !rd_en && evt_pulse == '0) |=> $stable(flag_vec));

endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_sel    (reg_sel),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .set_dir    (wdata[7]),
  .wsel       (wdata[NUM_SRC-1:0]),
  .evt_pulse  (evt_pulse),
  .irq        (irq),
  .flag_vec   (flag_vec),
  .mask_vec   (mask_vec),
  .any_pending(any_pending)
);

// File: tb/evt_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] evt_pulse = '0;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [4:0] m_flags = '0;
  logic [4:0] m_mask  = '0;
  logic       m_irq   = 1'b0;

  always #2.5 clk = ~clk;

  evt_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .evt_pulse(evt_pulse), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, check, then advance the model.
  task automatic op(input logic sel, input logic wr, input logic rd,
                    input logic [7:0] wd, input logic [4:0] ev, input string tag);
    logic [7:0] exp_rd;
    @(negedge clk);
    chk("R8 irq", {7'd0, irq}, {7'd0, m_irq});
    reg_sel = sel; wr_en = wr; rd_en = rd; wdata = wd; evt_pulse = ev;
    #1;
    if (rd) begin
      exp_rd = sel ? 8'h00 : {(|(m_flags & m_mask)), 2'b00, m_flags};
      chk(tag, rdata, exp_rd);
    end
    @(posedge clk);
    m_irq = |(m_flags & m_mask);
    m_flags = ((rd && !sel) ? 5'd0 : m_flags) | ev;
    if (wr && sel)
      m_mask = wd[7] ? (m_mask | wd[4:0]) : (m_mask & ~wd[4:0]);
  endtask

  task automatic idle();
    op(1'b0, 1'b0, 1'b0, 8'h00, 5'd0, "idle");
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Expose each mask bit through a pulse on its source and a status read.
  task automatic probe_mask(input string tag);
    op(1'b0, 1'b0, 1'b1, 8'h00, 5'd0, "R6 drain");
    for (int b = 0; b < 5; b++) begin
      op(1'b0, 1'b0, 1'b0, 8'h00, 5'(1 << b), "evt");
      op(1'b0, 1'b0, 1'b1, 8'h00, 5'd0, tag);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    op(1'b0, 1'b0, 1'b1, 8'h00, 5'd0, "R1 status after reset");
    op(1'b1, 1'b0, 1'b1, 8'h00, 5'd0, "R9 mask read");

    // R2: every event pattern, two pulses accumulate, read returns the union
    for (int p = 0; p < 32; p++) begin
      op(1'b0, 1'b0, 1'b0, 8'h00, 5'(p), "evt");
      op(1'b0, 1'b0, 1'b0, 8'h00, 5'(31 - p) & 5'h15, "evt");
      idle();
      op(1'b0, 1'b0, 1'b1, 8'h00, 5'd0, "R2 sticky flags");
      op(1'b0, 1'b0, 1'b1, 8'h00, 5'd0, "R6 cleared after read");
    end

    // R3 / R4: mask set and clear sweep
    for (int v = 0; v < 32; v++) begin
      op(1'b1, 1'b1, 1'b0, {1'b1, 2'b00, 5'(v)}, 5'd0, "wr");
      probe_mask("R3 mask set");
      op(1'b1, 1'b1, 1'b0, {1'b0, 2'b11, 5'(v) ^ 5'h15}, 5'd0, "wr");
      probe_mask("R4 mask clear");
    end

    // R5: summary tracks flags AND mask live
    op(1'b1, 1'b1, 1'b0, 8'h1F, 5'd0, "wr");
    op(1'b1, 1'b1, 1'b0, 8'h81, 5'd0, "wr");
    op(1'b0, 1'b0, 1'b0, 8'h00, 5'h02, "evt");
    op(1'b0, 1'b0, 1'b1, 8'h00, 5'd0, "R5 unmasked flag no summary");
    op(1'b0, 1'b0, 1'b0, 8'h00, 5'h01, "evt");
    op(1'b0, 1'b0, 1'b1, 8'h00, 5'd0, "R5 summary set");

    // R7: event coincident with a clearing read survives
    op(1'b0, 1'b0, 1'b0, 8'h00, 5'h08, "evt");
    op(1'b0, 1'b0, 1'b1, 8'h00, 5'h04, "R7 read with event");
    op(1'b0, 1'b0, 1'b1, 8'h00, 5'd0, "R7 event kept");

    // R9: a status write alters nothing
    op(1'b0, 1'b0, 1'b0, 8'h00, 5'h11, "evt");
    op(1'b0, 1'b1, 1'b0, 8'hFF, 5'd0, "wr");
    op(1'b0, 1'b1, 1'b0, 8'h00, 5'd0, "wr");
    op(1'b0, 1'b0, 1'b1, 8'h00, 5'd0, "R9 status write ignored");
    op(1'b1, 1'b0, 1'b1, 8'h00, 5'd0, "R9 mask read zero");

    // R8: irq sequence around a masked event
    op(1'b1, 1'b1, 1'b0, 8'h90, 5'd0, "wr");
    op(1'b0, 1'b0, 1'b0, 8'h00, 5'h10, "evt");
    idle();
    idle();
    op(1'b0, 1'b0, 1'b1, 8'h00, 5'd0, "R8 read");
    idle();
    idle();
    summary();
  end

endmodule